// File: doc/BRIEF.md
# Address-Matched Memory Write Error Injector

This block sits in the write path of one memory channel and deliberately corrupts selected write transactions, so that the error detection and reporting logic further on can be exercised. Software loads three settings: a 42-bit address-match word, a 32-bit check-bit flip mask and a 5-bit control word. The match word and the flip mask go first into staging registers. They become active only when a nonzero control word is written, which arms injection.

Each request arrives with its decoded DIMM, rank, bank, page and column fields, a 64-byte line and 32 check bits. It leaves one cycle later with the same fields. A write whose address matches while injection is armed has its check bits inverted according to the mask and the selected half-lines. It can also have its address parity bit inverted. A one-cycle pulse marks the injection, and a class output tells a correctable error from an uncorrectable one. Reads always pass through untouched.

Top module: `mem_wr_err_inject`

## Requirements
- R1: Match word layout: column in bits 13:0, page in bits 29:14, bank in bits 33:30. A write hits only when every non-wildcard field equals the staged value.
- R2: Bits 36:34 hold rank and DIMM. When `many_dimms_i`=1, DIMM is bits 36:35 and rank is bit 34. When it is 0, DIMM is bit 36 and rank is bits 35:34, and the missing upper bit of the request field must be 0.
- R3: Bits 37..41 are don't-care flags for column, page, bank, rank and DIMM respectively. A set flag removes that field from the comparison.
- R4: Every request appears on the outputs exactly one cycle later with identical fields and data. A read is never corrupted and never raises `inj_o`.
- R5: With control bit 0 (repeat) clear, only the first matching write after arming is corrupted. Writing the control word again re-arms.
- R6: With repeat set, every matching write is corrupted until the control word is written to zero.
- R7: When control bit 3 (check-bit error) is set, every set mask bit inverts the matching check bit. Bits 15:0 are affected only if control bit 1 (lower half) is set, and bits 31:16 only if control bit 2 (upper half) is set.
- R8: `inj_uncorr_o`=1 when the applied flips touch both aligned 16-bit symbol pairs (15:0 and 31:16). Otherwise an injection is correctable (`inj_uncorr_o`=0).
- R9: Writing control 0 disarms from the next cycle on. Match and mask writes take effect only at the next nonzero control write. A control word with neither bit 3 nor bit 4 set never injects.
- R10: Control bit 4 inverts `out_par_o` on an injected write, independently of the mask and of the half-line bits.
- R11: Config selector: 0 = match word, 1 = flip mask, 2 = control word. After reset nothing is armed, and `out_valid_o` and `inj_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Register select: 0 match, 1 mask, 2 control |
| cfg_wdata_i | input | 42 | Configuration write data |
| many_dimms_i | input | 1 | More than two DIMMs per channel (static) |
| req_valid_i | input | 1 | Request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_dimm_i | input | 2 | DIMM index |
| req_rank_i | input | 2 | Rank index |
| req_bank_i | input | 4 | Bank |
| req_page_i | input | 16 | Page (row) |
| req_col_i | input | 14 | Column |
| req_data_i | input | 512 | Line data |
| req_chk_i | input | 32 | Check bits |
| req_par_i | input | 1 | Address parity bit |
| out_valid_o | output | 1 | Request valid, one cycle later |
| out_write_o | output | 1 | Write flag |
| out_dimm_o | output | 2 | DIMM index |
| out_rank_o | output | 2 | Rank index |
| out_bank_o | output | 4 | Bank |
| out_page_o | output | 16 | Page |
| out_col_o | output | 14 | Column |
| out_data_o | output | 512 | Line data, unchanged |
| out_chk_o | output | 32 | Check bits after corruption |
| out_par_o | output | 1 | Parity after corruption |
| inj_o | output | 1 | Pulse: this output beat was corrupted |
| inj_uncorr_o | output | 1 | Injected error is uncorrectable |

## Verification
The bench builds the block with its default field widths: 14-bit column, 16-bit page, 4-bit bank, a 64-byte line and 32 check bits. These put every match-word flag and the rank/DIMM boundary at the bit positions the requirements name. The bench drives `many_dimms_i` both ways so that both rank/DIMM splits are reached. It also uses masks that fall inside one symbol pair, across both pairs, and gated off by either half-line bit, so that both error classes and a zero-flip injection occur.

// File: rtl/errinj_pkg.sv
package errinj_pkg;
  localparam int CTRL_W = 5;

  typedef enum logic [1:0] {
    SEL_MATCH = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_CTRL  = 2'd2
  } cfg_sel_e;

  // bit 0 is repeat_en, bit 4 is par_req
  typedef struct packed {
    logic par_req;
    logic ecc_req;
    logic hi_half;
    logic lo_half;
    logic repeat_en;
  } ctrl_t;
endpackage

// File: rtl/errinj_cfg.sv
module errinj_cfg
  import errinj_pkg::*;
#(
  parameter int MATCH_W = 42,
  parameter int CHK_W   = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [1:0]         sel_i,
  input  logic [MATCH_W-1:0] wdata_i,
  input  logic               fire_i,
  output logic [MATCH_W-1:0] act_match_o,
  output logic [CHK_W-1:0]   act_mask_o,
  output ctrl_t              ctrl_o,
  output logic               armed_o
);
  logic [MATCH_W-1:0] stg_match_q;
  logic [CHK_W-1:0]   stg_mask_q;
  ctrl_t              ctrl_q;
  logic               fired_q;
  ctrl_t              ctrl_new;

  assign ctrl_new = ctrl_t'(wdata_i[CTRL_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_match_q <= '0;
      stg_mask_q  <= '0;
      act_match_o <= '0;
      act_mask_o  <= '0;
      ctrl_q      <= '0;
      fired_q     <= 1'b0;
    end else begin
      if (fire_i && !ctrl_q.repeat_en) fired_q <= 1'b1;
      if (we_i) begin
        unique case (cfg_sel_e'(sel_i))
          SEL_MATCH: stg_match_q <= wdata_i;
          SEL_MASK:  stg_mask_q  <= wdata_i[CHK_W-1:0];
          SEL_CTRL: begin
            ctrl_q  <= ctrl_new;
            fired_q <= 1'b0;
            // staged settings become live only on arming
            if (ctrl_new != '0) begin
              act_match_o <= stg_match_q;
              act_mask_o  <= stg_mask_q;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ctrl_o  = ctrl_q;
  assign armed_o = (ctrl_q.ecc_req || ctrl_q.par_req) &&
                   (ctrl_q.repeat_en || !fired_q);
endmodule

// File: rtl/errinj_match.sv
module errinj_match #(
  parameter int COL_W  = 14,
  parameter int PAGE_W = 16,
  parameter int BANK_W = 4,
  localparam int PAGE_LSB = COL_W,
  localparam int BANK_LSB = PAGE_LSB + PAGE_W,
  localparam int RD_LSB   = BANK_LSB + BANK_W,
  localparam int FLAG_LSB = RD_LSB + 3,
  localparam int MATCH_W  = FLAG_LSB + 5
) (
  input  logic [MATCH_W-1:0] match_i,
  input  logic               many_dimms_i,
  input  logic [1:0]         dimm_i,
  input  logic [1:0]         rank_i,
  input  logic [BANK_W-1:0]  bank_i,
  input  logic [PAGE_W-1:0]  page_i,
  input  logic [COL_W-1:0]   col_i,
  output logic               hit_o
);
  logic [2:0] rd;
  logic [1:0] want_dimm, want_rank;
  logic [4:0] any_f;   // col, page, bank, rank, dimm
  logic [4:0] eq_f;

  assign rd    = match_i[RD_LSB +: 3];
  assign any_f = match_i[FLAG_LSB +: 5];

  always_comb begin
    if (many_dimms_i) begin
      want_dimm = rd[2:1];
      want_rank = {1'b0, rd[0]};
    end else begin
      want_dimm = {1'b0, rd[2]};
      want_rank = rd[1:0];
    end
  end

  assign eq_f[0] = col_i  == match_i[0 +: COL_W];
  assign eq_f[1] = page_i == match_i[PAGE_LSB +: PAGE_W];
  assign eq_f[2] = bank_i == match_i[BANK_LSB +: BANK_W];
  assign eq_f[3] = rank_i == want_rank;
  assign eq_f[4] = dimm_i == want_dimm;

  assign hit_o = &(eq_f | any_f);
endmodule

// File: rtl/errinj_corrupt.sv
module errinj_corrupt
  import errinj_pkg::*;
#(
  parameter int CHK_W  = 32,
  parameter int PAIR_W = 16,
  localparam int HALF_W = CHK_W / 2,
  localparam int N_PAIR = CHK_W / PAIR_W
) (
  input  ctrl_t            ctrl_i,
  input  logic [CHK_W-1:0] mask_i,
  output logic [CHK_W-1:0] flip_o,
  output logic             uncorr_o
);
  logic [1:0]        half_en;
  logic [N_PAIR-1:0] pair_hit;

  assign half_en = {ctrl_i.hi_half, ctrl_i.lo_half};

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign flip_o[h*HALF_W +: HALF_W] =
      (ctrl_i.ecc_req && half_en[h]) ? mask_i[h*HALF_W +: HALF_W] : '0;
  end

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    assign pair_hit[p] = |flip_o[p*PAIR_W +: PAIR_W];
  end

  // more than one symbol pair touched -> uncorrectable
  assign uncorr_o = $countones(pair_hit) > 1;
endmodule

// File: rtl/mem_wr_err_inject.sv
module mem_wr_err_inject
  import errinj_pkg::*;
#(
  parameter int COL_W      = 14,
  parameter int PAGE_W     = 16,
  parameter int BANK_W     = 4,
  parameter int LINE_BYTES = 64,
  parameter int CHK_W      = 32,
  localparam int DATA_W  = LINE_BYTES * 8,
  localparam int MATCH_W = COL_W + PAGE_W + BANK_W + 3 + 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_sel_i,
  input  logic [MATCH_W-1:0] cfg_wdata_i,
  input  logic               many_dimms_i,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [1:0]         req_dimm_i,
  input  logic [1:0]         req_rank_i,
  input  logic [BANK_W-1:0]  req_bank_i,
  input  logic [PAGE_W-1:0]  req_page_i,
  input  logic [COL_W-1:0]   req_col_i,
  input  logic [DATA_W-1:0]  req_data_i,
  input  logic [CHK_W-1:0]   req_chk_i,
  input  logic               req_par_i,
  output logic               out_valid_o,
  output logic               out_write_o,
  output logic [1:0]         out_dimm_o,
  output logic [1:0]         out_rank_o,
  output logic [BANK_W-1:0]  out_bank_o,
  output logic [PAGE_W-1:0]  out_page_o,
  output logic [COL_W-1:0]   out_col_o,
  output logic [DATA_W-1:0]  out_data_o,
  output logic [CHK_W-1:0]   out_chk_o,
  output logic               out_par_o,
  output logic               inj_o,
  output logic               inj_uncorr_o
);
  logic [MATCH_W-1:0] act_match;
  logic [CHK_W-1:0]   act_mask;
  ctrl_t              ctrl;
  logic               armed;
  logic               hit;
  logic               fire;
  logic [CHK_W-1:0]   flip;
  logic               uncorr;

  errinj_cfg #(.MATCH_W(MATCH_W), .CHK_W(CHK_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i        (cfg_we_i),
    .sel_i       (cfg_sel_i),
    .wdata_i     (cfg_wdata_i),
    .fire_i      (fire),
    .act_match_o (act_match),
    .act_mask_o  (act_mask),
    .ctrl_o      (ctrl),
    .armed_o     (armed)
  );

  errinj_match #(.COL_W(COL_W), .PAGE_W(PAGE_W), .BANK_W(BANK_W)) u_match (
    .match_i      (act_match),
    .many_dimms_i (many_dimms_i),
    .dimm_i       (req_dimm_i),
    .rank_i       (req_rank_i),
    .bank_i       (req_bank_i),
    .page_i       (req_page_i),
    .col_i        (req_col_i),
    .hit_o        (hit)
  );

  errinj_corrupt #(.CHK_W(CHK_W)) u_corrupt (
    .ctrl_i   (ctrl),
    .mask_i   (act_mask),
    .flip_o   (flip),
    .uncorr_o (uncorr)
  );

  assign fire = req_valid_i && req_write_i && hit && armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      out_write_o  <= 1'b0;
      out_dimm_o   <= '0;
      out_rank_o   <= '0;
      out_bank_o   <= '0;
      out_page_o   <= '0;
      out_col_o    <= '0;
      out_data_o   <= '0;
      out_chk_o    <= '0;
      out_par_o    <= 1'b0;
      inj_o        <= 1'b0;
      inj_uncorr_o <= 1'b0;
    end else begin
      out_valid_o  <= req_valid_i;
      inj_o        <= fire;
      inj_uncorr_o <= fire && uncorr;
      if (req_valid_i) begin
        out_write_o <= req_write_i;
        out_dimm_o  <= req_dimm_i;
        out_rank_o  <= req_rank_i;
        out_bank_o  <= req_bank_i;
        out_page_o  <= req_page_i;
        out_col_o   <= req_col_i;
        out_data_o  <= req_data_i;
        out_chk_o   <= fire ? (req_chk_i ^ flip) : req_chk_i;
        out_par_o   <= req_par_i ^ (fire && ctrl.par_req);
      end
    end
  end
endmodule

// File: rtl/errinj_chk.sv
module errinj_chk
  import errinj_pkg::*;
#(
  parameter int CHK_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [CHK_W-1:0] req_chk_i,
  input logic             req_par_i,
  input ctrl_t            ctrl,
  input logic             armed,
  input logic             out_valid_o,
  input logic             out_write_o,
  input logic [CHK_W-1:0] out_chk_o,
  input logic             out_par_o,
  input logic             inj_o,
  input logic             inj_uncorr_o
);
  a_r4_read_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_write_o |-> !inj_o);

  a_r4_inj_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_o |-> out_valid_o && out_write_o);

  a_r9_off_no_inj: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && ctrl == '0 |=> !inj_o);

  a_r5_spent_no_inj: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !armed |=> !inj_o);

  a_r8_class_needs_inj: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_uncorr_o |-> inj_o);

  a_r7_chk_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i ##1 (out_valid_o && !inj_o) |-> out_chk_o == $past(req_chk_i));

  a_r10_par_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i ##1 (out_valid_o && !inj_o) |-> out_par_o == $past(req_par_i));
endmodule

bind mem_wr_err_inject errinj_chk #(.CHK_W(CHK_W)) u_chk (
  .clk_i, .rst_ni, .req_valid_i, .req_chk_i, .req_par_i,
  .ctrl, .armed, .out_valid_o, .out_write_o, .out_chk_o, .out_par_o,
  .inj_o, .inj_uncorr_o
);

// File: tb/tb_mem_wr_err_inject.sv
module tb_mem_wr_err_inject;
  logic clk_i = 0, rst_ni = 0;
  always #10 clk_i = ~clk_i;

  logic         cfg_we_i = 0;
  logic [1:0]   cfg_sel_i = 0;
  logic [41:0]  cfg_wdata_i = 0;
  logic         many_dimms_i = 0;
  logic         req_valid_i = 0, req_write_i = 0;
  logic [1:0]   req_dimm_i = 0, req_rank_i = 0;
  logic [3:0]   req_bank_i = 0;
  logic [15:0]  req_page_i = 0;
  logic [13:0]  req_col_i = 0;
  logic [511:0] req_data_i = 0;
  logic [31:0]  req_chk_i = 0;
  logic         req_par_i = 0;
  logic         out_valid_o, out_write_o, out_par_o, inj_o, inj_uncorr_o;
  logic [1:0]   out_dimm_o, out_rank_o;
  logic [3:0]   out_bank_o;
  logic [15:0]  out_page_o;
  logic [13:0]  out_col_o;
  logic [511:0] out_data_o;
  logic [31:0]  out_chk_o;

  mem_wr_err_inject dut (.*);

  int checks = 0, errors = 0, inj_seen = 0;
  string tag = "R11";
  bit done = 0;

  // reference state
  logic [41:0] s_match, a_match;
  logic [31:0] s_mask, a_mask;
  logic [4:0]  m_ctrl;
  bit          m_fired;
  bit          e_valid, e_write, e_par, e_inj, e_unc;
  logic [31:0] e_chk;
  logic [511:0] e_data;
  logic [37:0] e_fields;

  function automatic bit ref_hit(logic [1:0] d, logic [1:0] r, logic [3:0] b,
                                 logic [15:0] p, logic [13:0] c);
    int rd = int'(a_match[36:34]);
    int wd, wr;
    if (many_dimms_i) begin wd = rd / 2; wr = rd % 2; end
    else begin wd = rd / 4; wr = rd % 4; end
    return (a_match[37] || c == a_match[13:0]) && (a_match[38] || p == a_match[29:14]) &&
           (a_match[39] || b == a_match[33:30]) && (a_match[40] || int'(r) == wr) &&
           (a_match[41] || int'(d) == wd);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_match = 0; a_match = 0; s_mask = 0; a_mask = 0; m_ctrl = 0; m_fired = 0;
      e_valid = 0; e_inj = 0; e_unc = 0;
    end else begin
      e_valid = req_valid_i; e_inj = 0; e_unc = 0;
      if (req_valid_i) begin
        logic [31:0] fl;
        bit ev;
        ev = req_write_i && ref_hit(req_dimm_i, req_rank_i, req_bank_i, req_page_i, req_col_i)
             && (m_ctrl[3] || m_ctrl[4]) && (m_ctrl[0] || !m_fired);
        fl = 0;
        if (m_ctrl[3] && m_ctrl[1]) fl[15:0]  = a_mask[15:0];
        if (m_ctrl[3] && m_ctrl[2]) fl[31:16] = a_mask[31:16];
        e_write = req_write_i; e_data = req_data_i;
        e_fields = {req_dimm_i, req_rank_i, req_bank_i, req_page_i, req_col_i};
        e_chk = ev ? req_chk_i ^ fl : req_chk_i;
        e_par = req_par_i ^ (ev && m_ctrl[4]);
        e_inj = ev;
        e_unc = ev && (fl[15:0] != 0) && (fl[31:16] != 0);
        if (ev && !m_ctrl[0]) m_fired = 1;
      end
      if (cfg_we_i) begin
        case (cfg_sel_i)
          2'd0: s_match = cfg_wdata_i;
          2'd1: s_mask = cfg_wdata_i[31:0];
          2'd2: begin
            m_ctrl = cfg_wdata_i[4:0]; m_fired = 0;
            if (m_ctrl != 0) begin a_match = s_match; a_mask = s_mask; end
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    if (!e_valid) begin
      chk(!out_valid_o && !inj_o, "idle", {out_valid_o, inj_o}, 0);
    end else begin
      chk(out_valid_o && out_chk_o == e_chk && out_par_o == e_par, "chk/par",
          {out_valid_o, out_par_o, out_chk_o}, {1'b1, e_par, e_chk});
      chk(inj_o == e_inj && inj_uncorr_o == e_unc, "inj/class",
          {inj_o, inj_uncorr_o}, {e_inj, e_unc});
      chk(out_write_o == e_write && out_data_o == e_data &&
          {out_dimm_o, out_rank_o, out_bank_o, out_page_o, out_col_o} == e_fields,
          "pass-through", {out_write_o, out_page_o, out_col_o}, {e_write, e_fields[27:0]});
      if (inj_o) inj_seen++;
    end
  endtask

  task automatic step();
    @(posedge clk_i); @(negedge clk_i); compare();
  endtask

  task automatic cfg(logic [1:0] sel, logic [41:0] v);
    cfg_we_i = 1; cfg_sel_i = sel; cfg_wdata_i = v; step(); cfg_we_i = 0;
  endtask

  task automatic req(bit w, logic [1:0] d, logic [1:0] r, logic [3:0] b,
                     logic [15:0] p, logic [13:0] c);
    req_valid_i = 1; req_write_i = w; req_dimm_i = d; req_rank_i = r;
    req_bank_i = b; req_page_i = p; req_col_i = c;
    for (int i = 0; i < 16; i++) req_data_i[i*32 +: 32] = $urandom;
    req_chk_i = $urandom; req_par_i = $urandom % 2;
    step(); req_valid_i = 0;
  endtask

  function automatic logic [41:0] mk(logic [4:0] any, logic [1:0] d, logic [1:0] r,
                                     logic [3:0] b, logic [15:0] p, logic [13:0] c, bit many);
    logic [2:0] rd = many ? {d, r[0]} : {d[0], r};
    return {any, rd, b, p, c};
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!out_valid_o && !inj_o, "reset state R11", {out_valid_o, inj_o}, 0);
    rst_ni = 1;
    step();

    tag = "R4"; // all-wildcard, repeat, lower half, ECC
    cfg(0, mk(5'h1f, 0, 0, 0, 0, 0, 0)); cfg(1, 32'h0000_0001); cfg(2, 5'b01011);
    req(0, 1, 2, 3, 16'h55, 14'h7); req(1, 1, 2, 3, 16'h55, 14'h7);

    tag = "R6";
    for (int i = 0; i < 4; i++) req(1, 2'(i), 2'(i), 4'(i), 16'(i*7), 14'(i*3));

    tag = "R1";
    cfg(0, mk(0, 0, 1, 4'h5, 16'h1234, 14'h2aa, 0)); cfg(2, 5'b01011);
    req(1, 0, 1, 4'h5, 16'h1234, 14'h2aa); req(1, 0, 1, 4'h5, 16'h1234, 14'h2ab);
    req(1, 0, 1, 4'h5, 16'h1235, 14'h2aa); req(1, 0, 1, 4'h6, 16'h1234, 14'h2aa);

    tag = "R2";
    cfg(0, mk(0, 1, 2, 4'h1, 16'h9, 14'h9, 0)); cfg(2, 5'b01011);
    req(1, 1, 2, 4'h1, 16'h9, 14'h9); req(1, 0, 2, 4'h1, 16'h9, 14'h9);
    req(1, 3, 2, 4'h1, 16'h9, 14'h9);
    many_dimms_i = 1;
    cfg(0, mk(0, 3, 1, 4'h1, 16'h9, 14'h9, 1)); cfg(2, 5'b01011);
    req(1, 3, 1, 4'h1, 16'h9, 14'h9); req(1, 3, 0, 4'h1, 16'h9, 14'h9);
    req(1, 1, 1, 4'h1, 16'h9, 14'h9);
    many_dimms_i = 0;

    tag = "R3";
    for (int f = 0; f < 5; f++) begin
      cfg(0, mk(5'(1 << f), 1, 1, 4'h2, 16'h20, 14'h30, 0)); cfg(2, 5'b01011);
      req(1, f == 4 ? 2'd0 : 2'd1, f == 3 ? 2'd0 : 2'd1, f == 2 ? 4'h3 : 4'h2,
          f == 1 ? 16'h21 : 16'h20, f == 0 ? 14'h31 : 14'h30);
      req(1, 0, 0, 4'h3, 16'h21, 14'h31);
    end

    tag = "R5"; // one-shot
    cfg(0, mk(5'h1f, 0, 0, 0, 0, 0, 0)); cfg(2, 5'b01010);
    inj_seen = 0;
    for (int i = 0; i < 3; i++) req(1, 0, 0, 0, 0, 0);
    chk(inj_seen == 1, "one-shot count R5", 64'(inj_seen), 1);
    cfg(2, 5'b01010); inj_seen = 0;
    for (int i = 0; i < 2; i++) req(1, 0, 0, 0, 0, 0);
    chk(inj_seen == 1, "re-arm count R5", 64'(inj_seen), 1);

    tag = "R7";
    cfg(1, 32'h0001_0001); cfg(2, 5'b01011); req(1, 0, 0, 0, 0, 0);
    cfg(2, 5'b01101); req(1, 0, 0, 0, 0, 0);
    cfg(2, 5'b01001); req(1, 0, 0, 0, 0, 0);

    tag = "R8";
    cfg(2, 5'b01111); req(1, 0, 0, 0, 0, 0);
    cfg(1, 32'h0000_8101); cfg(2, 5'b01111); req(1, 0, 0, 0, 0, 0);
    cfg(1, 32'hff00_0000); cfg(2, 5'b01111); req(1, 0, 0, 0, 0, 0);

    tag = "R9";
    cfg(2, 5'b00000); req(1, 0, 0, 0, 0, 0);
    cfg(2, 5'b00111); req(1, 0, 0, 0, 0, 0);
    cfg(2, 5'b01111);
    cfg(0, mk(0, 1, 1, 1, 1, 1, 0)); cfg(1, 32'h1);
    req(1, 0, 0, 0, 0, 0);
    cfg(2, 5'b01111); req(1, 0, 0, 0, 0, 0); req(1, 1, 1, 1, 1, 1);

    tag = "R10";
    cfg(0, mk(5'h1f, 0, 0, 0, 0, 0, 0)); cfg(1, 32'hffff_ffff);
    cfg(2, 5'b10111); req(1, 0, 0, 0, 0, 0); req(0, 0, 0, 0, 0, 0);
    cfg(2, 5'b11001); req(1, 2, 1, 0, 0, 0);

    step(); step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog %s actual=hung expected=done", tag);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule